// File: doc/BRIEF.md
# SRAM Sleep-Mode Power-Down Controller

This block sits between the pins of a synchronous SRAM and its core and manages a low-current sleep state. An active-high sleep request that is asynchronous to the clock is synchronised with a two-flop chain. A four-state machine (awake, entering, asleep, recovering) then turns that request into the control signals that gate the core: a core enable, an input disable, an output high-impedance control and a recovery-busy flag.

Once the synchronised request is seen, all pin inputs other than the request are ignored and the data outputs go to high impedance. The core enable stays on for a programmable entry delay, so that the low-current state is reached only after that delay. The device stays asleep for as long as the request stays high. When the request falls, a programmable recovery window follows. In that window, deselect and read commands pass to the core, and a write is dropped and flagged for the cycle in which it arrives. Any operation already in flight when the request rises is not guaranteed to complete. The surrounding system must not start sleep while an operation is pending.

Top module: `sleep_pd_ctrl`

## Requirements
- R1: A change of `sleep_req` reaches the state-driven outputs at the third rising clock edge after the change, through a two-flop synchroniser.
- R2: When the synchronised request rises from the awake state, `in_disable` and `out_hiz` go high at once, and `core_en` stays high for exactly ENTRY_CYC cycles (entry delay).
- R3: After the entry delay, `core_en` is low and stays low for as long as the synchronised request is high. While `core_en` is low, `in_disable` and `out_hiz` are high.
- R4: While `in_disable` is high, `cmd_out` is deselect (2'b00) for every value of `cmd_in`, and `cmd_reject` stays low.
- R5: When the synchronised request falls, `in_disable` and `out_hiz` drop and `core_en` is high. `recov_busy` is then high for exactly RECOVER_CYC cycles before the block returns to the awake state.
- R6: While `recov_busy` is high, a write (`cmd_in` = 2'b10) is forwarded as deselect (2'b00) and `cmd_reject` is high in that same cycle. Read (2'b01) and deselect (2'b00) are forwarded unchanged.
- R7: In the awake state, deselect, read and write are forwarded unchanged, all control flags other than `core_en` are low, and the reserved code 2'b11 is forwarded as deselect in every state.
- R8: If the request rises during recovery, the entry delay restarts. If the request falls during the entry delay, recovery starts at once without reaching the asleep state.
- R9: While `rst_n` is low, the block is in the awake state (`core_en` high, every other flag low) and the synchroniser holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| cmd_in | input | 2 | Incoming command: 00 deselect, 01 read, 10 write, 11 reserved |
| core_en | output | 1 | Core enable; low in the low-current state |
| in_disable | output | 1 | High while pin inputs other than the request are ignored |
| out_hiz | output | 1 | High while the data outputs are in high impedance |
| recov_busy | output | 1 | High during the wake-up recovery window |
| cmd_out | output | 2 | Command forwarded to the core, same encoding as `cmd_in` |
| cmd_reject | output | 1 | One-cycle pulse when a write is dropped during recovery |

## Verification
The bench builds the block with ENTRY_CYC = 4 and RECOVER_CYC = 5. These values are short enough that every state boundary can be reached many times within a short run. They are also distinct, so a swap of the entry and recovery counts shows up as a wrong cycle. With these lengths, the bench can drop the request part-way through the entry delay and raise it again part-way through recovery, which exercises the restart paths of R8. The bench also checks the exact edge at which each flag changes against the three-edge synchroniser latency.

// File: rtl/sleep_pd_pkg.sv
// Shared types for the sleep power-down controller.
// Assumes: two-bit command encoding used by the whole core interface.
package sleep_pd_pkg;

    typedef enum logic [1:0] {
        PD_AWAKE      = 2'd0,
        PD_ENTERING   = 2'd1,
        PD_ASLEEP     = 2'd2,
        PD_RECOVERING = 2'd3
    } pd_state_t;

    localparam logic [1:0] CMD_DESEL = 2'b00;
    localparam logic [1:0] CMD_READ  = 2'b01;
    localparam logic [1:0] CMD_WRITE = 2'b10;
    localparam logic [1:0] CMD_RSVD  = 2'b11;

endpackage

// File: rtl/sleep_pd_sync.sv
// Multi-flop synchroniser for the asynchronous sleep request.
// Assumes: STAGES >= 2; the output is a clean level in the clk domain.
module sleep_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_pd_timer.sv
// Loadable down-counter that times the entry and recovery windows.
// Assumes: load has priority over dec; zero is a plain compare.
module sleep_pd_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // load a new window length or count one cycle down
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (load)                 cnt_q <= load_val;
        else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sleep_pd_fsm.sv
// Four-state sleep sequencer: awake, entering, asleep, recovering.
// Assumes: ENTRY_CYC, RECOVER_CYC >= 1; the timer is loaded with length-1
// on entry to a timed state, so that state lasts exactly that many cycles.
module sleep_pd_fsm
    import sleep_pd_pkg::*;
#(
    parameter int ENTRY_CYC   = 4,
    parameter int RECOVER_CYC = 5,
    parameter int CW          = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_s,
    input  logic          tmr_zero,
    output pd_state_t     state,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          tmr_dec
);
    localparam logic [CW-1:0] ENTRY_LOAD   = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] RECOVER_LOAD = CW'(RECOVER_CYC - 1);

    pd_state_t state_q, state_d;

    // choose the next state and the timer action
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        unique case (state_q)
            PD_AWAKE: begin
                if (sleep_s) begin
                    state_d  = PD_ENTERING;
                    tmr_load = 1'b1;
                    tmr_val  = ENTRY_LOAD;
                end
            end
            PD_ENTERING: begin
                if (!sleep_s) begin
                    state_d  = PD_RECOVERING;
                    tmr_load = 1'b1;
                    tmr_val  = RECOVER_LOAD;
                end else if (tmr_zero) begin
                    state_d  = PD_ASLEEP;
                end else begin
                    tmr_dec  = 1'b1;
                end
            end
            PD_ASLEEP: begin
                if (!sleep_s) begin
                    state_d  = PD_RECOVERING;
                    tmr_load = 1'b1;
                    tmr_val  = RECOVER_LOAD;
                end
            end
            PD_RECOVERING: begin
                if (sleep_s) begin
                    state_d  = PD_ENTERING;
                    tmr_load = 1'b1;
                    tmr_val  = ENTRY_LOAD;
                end else if (tmr_zero) begin
                    state_d  = PD_AWAKE;
                end else begin
                    tmr_dec  = 1'b1;
                end
            end
            default: state_d = PD_AWAKE;
        endcase
    end

    // register the sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PD_AWAKE;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/sleep_pd_gate.sv
// Decodes the sequencer state into pin controls and filters commands.
// Assumes: purely combinational; cmd_in is already in the clk domain.
module sleep_pd_gate
    import sleep_pd_pkg::*;
(
    input  pd_state_t  state,
    input  logic [1:0] cmd_in,
    output logic       core_en,
    output logic       in_disable,
    output logic       out_hiz,
    output logic       recov_busy,
    output logic [1:0] cmd_out,
    output logic       cmd_reject
);
    logic hidden;

    // control levels straight from the state
    always_comb begin
        hidden     = (state == PD_ENTERING) || (state == PD_ASLEEP);
        core_en    = (state != PD_ASLEEP);
        in_disable = hidden;
        out_hiz    = hidden;
        recov_busy = (state == PD_RECOVERING);
    end

    // forward legal commands, drop writes in recovery, mask when hidden
    always_comb begin
        cmd_out    = cmd_in;
        cmd_reject = 1'b0;
        if (hidden || cmd_in == CMD_RSVD) begin
            cmd_out = CMD_DESEL;
        end else if (state == PD_RECOVERING && cmd_in == CMD_WRITE) begin
            cmd_out    = CMD_DESEL;
            cmd_reject = 1'b1;
        end
    end
endmodule

// File: rtl/sleep_pd_ctrl.sv
// Top of the sleep power-down controller.
// Assumes: sleep_req may change at any time; cmd_in is synchronous to clk;
// the system does not raise sleep_req while an operation is pending.
module sleep_pd_ctrl
    import sleep_pd_pkg::*;
#(
    parameter int ENTRY_CYC   = 4,
    parameter int RECOVER_CYC = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic [1:0] cmd_in,
    output logic       core_en,
    output logic       in_disable,
    output logic       out_hiz,
    output logic       recov_busy,
    output logic [1:0] cmd_out,
    output logic       cmd_reject
);
    localparam int MAXC = (ENTRY_CYC > RECOVER_CYC) ? ENTRY_CYC : RECOVER_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic          sleep_s;
    logic          tmr_zero;
    logic          tmr_load;
    logic          tmr_dec;
    logic [CW-1:0] tmr_val;
    pd_state_t     state;

    sleep_pd_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(sleep_req), .sync_out(sleep_s)
    );

    sleep_pd_timer #(.W(CW)) timer_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .dec(tmr_dec), .zero(tmr_zero)
    );

    sleep_pd_fsm #(.ENTRY_CYC(ENTRY_CYC), .RECOVER_CYC(RECOVER_CYC), .CW(CW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sleep_s(sleep_s), .tmr_zero(tmr_zero),
        .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_dec(tmr_dec)
    );

    sleep_pd_gate gate_i (
        .state(state), .cmd_in(cmd_in), .core_en(core_en),
        .in_disable(in_disable), .out_hiz(out_hiz), .recov_busy(recov_busy),
        .cmd_out(cmd_out), .cmd_reject(cmd_reject)
    );
endmodule

// File: rtl/sleep_pd_ctrl_chk.sv
// Port-level property checker for sleep_pd_ctrl, attached by bind.
// Assumes: same command encoding as sleep_pd_pkg.
module sleep_pd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd_in,
    input logic       core_en,
    input logic       in_disable,
    input logic       out_hiz,
    input logic       recov_busy,
    input logic [1:0] cmd_out,
    input logic       cmd_reject
);
    // R3: the core may only be off while the pins are isolated
    a_r3_off_means_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |-> (in_disable && out_hiz));

    // R2: the first cycle of isolation still has the core powered
    a_r2_entry_keeps_core: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_disable) |-> core_en);

    // R4: isolated pins forward only deselect and never reject
    a_r4_isolated_desel: assert property (@(posedge clk) disable iff (!rst_n)
        in_disable |-> (cmd_out == 2'b00 && !cmd_reject));

    // R5: recovery never overlaps isolation and keeps the core on
    a_r5_recovery_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        recov_busy |-> (!in_disable && !out_hiz && core_en));

    // R6: no write reaches the core during recovery
    a_r6_no_write_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        recov_busy |-> (cmd_out != 2'b10));

    // R6: a reject is only ever a dropped write during recovery
    a_r6_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> (recov_busy && cmd_in == 2'b10 && cmd_out == 2'b00));
endmodule

bind sleep_pd_ctrl sleep_pd_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .core_en(core_en),
    .in_disable(in_disable), .out_hiz(out_hiz), .recov_busy(recov_busy),
    .cmd_out(cmd_out), .cmd_reject(cmd_reject)
);

// File: tb/sleep_pd_ctrl_tb_top.sv
// Scoreboard bench: the driver predicts each cycle's outputs from the
// requirements and queues them; the monitor compares before the next edge.
module sleep_pd_ctrl_tb_top;
    localparam int ENTRY_CYC   = 4;
    localparam int RECOVER_CYC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic [1:0] cmd_in = 2'b00;
    logic       core_en, in_disable, out_hiz, recov_busy, cmd_reject;
    logic [1:0] cmd_out;

    always #5 clk = ~clk;

    sleep_pd_ctrl #(.ENTRY_CYC(ENTRY_CYC), .RECOVER_CYC(RECOVER_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .cmd_in(cmd_in),
        .core_en(core_en), .in_disable(in_disable), .out_hiz(out_hiz),
        .recov_busy(recov_busy), .cmd_out(cmd_out), .cmd_reject(cmd_reject)
    );

    typedef struct {
        string      tag;
        logic [5:0] flags;   // core_en, in_disable, out_hiz, recov_busy, reject, 0
        logic [1:0] cmd;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    // bench model: 0 awake, 1 entering, 2 asleep, 3 recovering
    int   m_mode = 0;
    int   m_left = 0;
    logic m_s1 = 1'b0, m_s2 = 1'b0;

    function automatic string mode_tag(int md, logic [1:0] c);
        case (md)
            0: return (c == 2'b11) ? "R7" : "R7";
            1: return "R2/R4";
            2: return "R3/R4";
            default: return (c == 2'b10) ? "R6" : "R5";
        endcase
    endfunction

    // one cycle: drive at the falling edge, queue the prediction, then
    // advance the model across the coming rising edge
    task automatic drive(input logic rst, input logic req, input logic [1:0] c, input string scn);
        exp_t e;
        logic hid;
        logic rej;
        logic [1:0] co;
        @(negedge clk);
        rst_n     = rst;
        sleep_req = req;
        cmd_in    = c;
        hid = (m_mode == 1 || m_mode == 2);
        rej = (m_mode == 3 && c == 2'b10);
        co  = (hid || c == 2'b11 || rej) ? 2'b00 : c;
        e.tag   = {scn, " ", mode_tag(m_mode, c)};
        e.flags = {(m_mode != 2), hid, hid, (m_mode == 3), rej, 1'b0};
        e.cmd   = co;
        exp_q.push_back(e);
        if (!rst) begin
            m_mode = 0; m_left = 0; m_s1 = 1'b0; m_s2 = 1'b0;
        end else begin
            case (m_mode)
                0: if (m_s2) begin m_mode = 1; m_left = ENTRY_CYC; end
                1: if (!m_s2) begin m_mode = 3; m_left = RECOVER_CYC; end
                   else begin m_left--; if (m_left == 0) m_mode = 2; end
                2: if (!m_s2) begin m_mode = 3; m_left = RECOVER_CYC; end
                default: if (m_s2) begin m_mode = 1; m_left = ENTRY_CYC; end
                   else begin m_left--; if (m_left == 0) m_mode = 0; end
            endcase
            m_s2 = m_s1;
            m_s1 = req;
        end
    endtask

    // monitor: compare queued prediction just before the next rising edge
    always @(negedge clk) begin
        #4;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [5:0] got;
            e = exp_q.pop_front();
            got = {core_en, in_disable, out_hiz, recov_busy, cmd_reject, 1'b0};
            n_vec++;
            if (got !== e.flags || cmd_out !== e.cmd) begin
                n_fail++;
                $display("FAIL %s: flags=%b cmd=%b expected flags=%b cmd=%b",
                         e.tag, got, cmd_out, e.flags, e.cmd);
            end
        end
    end

    // watchdog
    initial begin
        #2000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state, request held high must not leak through reset
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 2'b10, "R9");
        drive(1'b1, 1'b0, 2'b00, "R9");
        // R7: awake pass-through of all codes
        for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 2'(i), "R7");
        // R1/R2/R3/R4: enter sleep and stay, cmds cycled
        for (int i = 0; i < 3 + ENTRY_CYC + 6; i++) drive(1'b1, 1'b1, 2'(i), "R1");
        // R5/R6: wake, recovery with all command codes, back to awake
        for (int i = 0; i < 3 + RECOVER_CYC + 4; i++) drive(1'b1, 1'b0, 2'(i + 2), "R6");
        // R8: drop during the entry delay
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b1, 2'b01, "R8");
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 2'b10, "R8");
        // R8: rise again during recovery, then sleep fully
        for (int i = 0; i < 3 + ENTRY_CYC + 3; i++) drive(1'b1, 1'b1, 2'b10, "R8");
        for (int i = 0; i < 3 + RECOVER_CYC + 3; i++) drive(1'b1, 1'b0, 2'(i), "R5");
        // R9: reset in the middle of sleep returns to awake
        for (int i = 0; i < 6; i++) drive(1'b1, 1'b1, 2'b01, "R3");
        for (int i = 0; i < 2; i++) drive(1'b0, 1'b0, 2'b01, "R9");
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 2'b10, "R7");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule